// File: doc/BRIEF.md
# Compressed Line Write Formatter

This block sits on the write path of a memory controller that stores 64-byte cache lines in two 32-byte sub-ranks, a lower one and a higher one. For every written-back line it receives the raw line, the size in bytes that a compressor achieved and the compressor's payload. It picks between storing the compressed or the raw form, builds the sub-rank images and raises the write enables of the sub-ranks that must be written. A read path can tell the two forms apart by a 15-bit marker at the start of the sub-rank that it reads first.

A compressed image starts with a two-byte header: the marker, then a flag bit set to one. The zero-padded payload follows. Its sub-rank is picked by the parity of the row. A raw line fills both sub-ranks, and on odd rows its halves trade places, so that the first half always lands in the sub-rank that a compressed line of that row would use. The flag position of a raw line cannot carry data safely. When the first half of a raw line happens to begin with the marker, the formatter forces that bit to zero and issues a one-bit write to a side region, which keeps the displaced value.

The marker is a held input, loaded once by the controller. All outputs are registered and appear one clock after the request.

Top module: `lwf_write_formatter`

## Requirements
- R1: During and right after synchronous reset, lo_we, hi_we and side_we are all 0.
- R2: A request with csize of 30 or less is stored compressed, with exactly one of lo_we/hi_we set. A request with csize of 31 or more is stored raw, with both set.
- R3: A compressed image has mark_pattern in bits [14:0], a 1 in bit 15, and payload byte k (payload bits [8k+7:8k]) in image bits [8k+23:8k+16]. The sub-rank that is not written outputs all zero data.
- R4: Payload bytes with index k >= csize are written as zero.
- R5: A compressed line goes to the lower sub-rank when row_odd is 0 and to the higher sub-rank when row_odd is 1.
- R6: A raw line on an even row writes line bits [255:0] to lo_data and bits [511:256] to hi_data.
- R7: A raw line on an odd row writes line bits [255:0] to hi_data and bits [511:256] to lo_data.
- R8: When a raw line's bits [14:0] equal mark_pattern, its bit 15 is stored as 0, side_we is 1 and side_bit carries the original bit 15. Otherwise side_we is 0 and the line is stored unchanged.
- R9: Outputs follow a request with one cycle of latency, wr_addr carries the request's addr, and a cycle without in_valid produces no write enable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mark_pattern | input | 15 | Marker value, held constant |
| in_valid | input | 1 | Write request present |
| addr | input | ADDR_W | Line address of the request |
| row_odd | input | 1 | Parity of the target row |
| line | input | 512 | Raw line, byte 0 in bits [7:0] |
| csize | input | 7 | Compressed size in bytes (0 to 64) |
| payload | input | 240 | Compressed payload, byte k in bits [8k+7:8k] |
| lo_we | output | 1 | Lower sub-rank write enable |
| lo_data | output | 256 | Lower sub-rank write data |
| hi_we | output | 1 | Higher sub-rank write enable |
| hi_data | output | 256 | Higher sub-rank write data |
| side_we | output | 1 | Side-region bit write enable |
| side_bit | output | 1 | Displaced flag-position value |
| wr_addr | output | ADDR_W | Address of the outputs' request |

## Verification
The raw-line placement and the marker-collision repair can fall in the same cycle: a raw line whose head matches the marker must be both swapped (on odd rows) and have its flag position cleared. The bench provokes this with colliding lines on even and odd rows, with both values of the displaced bit. It judges that the cleared bit appears in the sub-rank selected by parity, that the other half is untouched and that side_bit matches the original value.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
    localparam int SUB_BYTES  = 32;
    localparam int LINE_BYTES = 2 * SUB_BYTES;
    localparam int SUB_W      = SUB_BYTES * 8;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int MARK_W     = 15;
    localparam int HDR_W      = MARK_W + 1;
    localparam int PAY_BYTES  = SUB_BYTES - HDR_W / 8;
    localparam int PAY_W      = PAY_BYTES * 8;
    localparam int SIZE_W     = $clog2(LINE_BYTES + 1);

    typedef struct packed {
        logic fits;     // compressed form fits one sub-rank
        logic collide;  // raw head matches the marker
    } line_class_t;

    typedef struct packed {
        logic             we;
        logic [SUB_W-1:0] data;
    } sub_wr_t;

    function automatic logic [PAY_W-1:0] pad_payload(
        input logic [PAY_W-1:0]  p,
        input logic [SIZE_W-1:0] n
    );
        logic [PAY_W-1:0] r;
        for (int k = 0; k < PAY_BYTES; k++)
            r[8*k +: 8] = (k < int'(n)) ? p[8*k +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [HDR_W-1:0] make_header(input logic [MARK_W-1:0] m);
        return {1'b1, m};
    endfunction
endpackage

// File: rtl/lwf_classify.sv
module lwf_classify
    import lwf_pkg::*;
(
    input  logic [SIZE_W-1:0] csize,
    input  logic [MARK_W-1:0] head,
    input  logic [MARK_W-1:0] mark_pattern,
    output line_class_t       cls
);
    always_comb begin
        cls.fits    = (int'(csize) <= PAY_BYTES);
        cls.collide = (head == mark_pattern);
    end
endmodule

// File: rtl/lwf_image.sv
module lwf_image
    import lwf_pkg::*;
(
    input  line_class_t       cls,
    input  logic [MARK_W-1:0] mark_pattern,
    input  logic [SUB_W-1:0]  first_half,
    input  logic [SIZE_W-1:0] csize,
    input  logic [PAY_W-1:0]  payload,
    output logic [SUB_W-1:0]  comp_img,
    output logic [SUB_W-1:0]  raw_head,
    output logic              side_need,
    output logic              side_val
);
    always_comb begin
        comp_img  = {pad_payload(payload, csize), make_header(mark_pattern)};
        raw_head  = first_half;
        side_need = !cls.fits && cls.collide;
        side_val  = first_half[MARK_W];
        if (side_need)
            raw_head[MARK_W] = 1'b0;
    end
endmodule

// File: rtl/lwf_place.sv
module lwf_place
    import lwf_pkg::*;
(
    input  logic             fits,
    input  logic             row_odd,
    input  logic [SUB_W-1:0] comp_img,
    input  logic [SUB_W-1:0] raw_head,
    input  logic [SUB_W-1:0] raw_tail,
    output sub_wr_t          lo,
    output sub_wr_t          hi
);
    sub_wr_t near, far;

    always_comb begin
        if (fits) begin
            near = '{we: 1'b1, data: comp_img};
            far  = '{we: 1'b0, data: '0};
        end else begin
            near = '{we: 1'b1, data: raw_head};
            far  = '{we: 1'b1, data: raw_tail};
        end
        lo = row_odd ? far  : near;
        hi = row_odd ? near : far;
    end
endmodule

// File: rtl/lwf_write_formatter.sv
module lwf_write_formatter
    import lwf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MARK_W-1:0]    mark_pattern,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 row_odd,
    input  logic [LINE_W-1:0]    line,
    input  logic [SIZE_W-1:0]    csize,
    input  logic [PAY_W-1:0]     payload,
    output logic                 lo_we,
    output logic [SUB_W-1:0]     lo_data,
    output logic                 hi_we,
    output logic [SUB_W-1:0]     hi_data,
    output logic                 side_we,
    output logic                 side_bit,
    output logic [ADDR_W-1:0]    wr_addr
);
    line_class_t      cls;
    logic [SUB_W-1:0] comp_img, raw_head;
    logic             side_need, side_val;
    sub_wr_t          lo_n, hi_n;

    lwf_classify u_cls (
        .csize        (csize),
        .head         (line[MARK_W-1:0]),
        .mark_pattern (mark_pattern),
        .cls          (cls)
    );

    lwf_image u_img (
        .cls          (cls),
        .mark_pattern (mark_pattern),
        .first_half   (line[SUB_W-1:0]),
        .csize        (csize),
        .payload      (payload),
        .comp_img     (comp_img),
        .raw_head     (raw_head),
        .side_need    (side_need),
        .side_val     (side_val)
    );

    lwf_place u_plc (
        .fits     (cls.fits),
        .row_odd  (row_odd),
        .comp_img (comp_img),
        .raw_head (raw_head),
        .raw_tail (line[LINE_W-1:SUB_W]),
        .lo       (lo_n),
        .hi       (hi_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_we    <= 1'b0;
            hi_we    <= 1'b0;
            side_we  <= 1'b0;
            side_bit <= 1'b0;
            lo_data  <= '0;
            hi_data  <= '0;
            wr_addr  <= '0;
        end else begin
            lo_we    <= in_valid && lo_n.we;
            hi_we    <= in_valid && hi_n.we;
            side_we  <= in_valid && side_need;
            side_bit <= side_val;
            lo_data  <= lo_n.data;
            hi_data  <= hi_n.data;
            wr_addr  <= addr;
        end
    end
endmodule

// File: rtl/lwf_checker.sv
module lwf_checker
    import lwf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [MARK_W-1:0]    mark_pattern,
    input logic                 in_valid,
    input logic                 row_odd,
    input logic [SIZE_W-1:0]    csize,
    input logic                 lo_we,
    input logic [SUB_W-1:0]     lo_data,
    input logic                 hi_we,
    input logic [SUB_W-1:0]     hi_data,
    input logic                 side_we
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !lo_we && !hi_we && !side_we);

    assert_fit_one_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && (int'(csize) <= PAY_BYTES) |=> $countones({lo_we, hi_we}) == 1);

    assert_raw_both_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && (int'(csize) > PAY_BYTES) |=> lo_we && hi_we && !$past(rst));

    assert_even_lower_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && (int'(csize) <= PAY_BYTES) && !row_odd |=> lo_we && !hi_we);

    assert_odd_higher_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && (int'(csize) <= PAY_BYTES) && row_odd |=> hi_we && !lo_we);

    assert_header_R3: assert property (@(posedge clk) disable iff (rst)
        lo_we && !hi_we |-> lo_data[HDR_W-1:0] == {1'b1, $past(mark_pattern)});

    assert_side_raw_R8: assert property (@(posedge clk) disable iff (rst)
        side_we |-> lo_we && hi_we && (!lo_data[MARK_W] || !hi_data[MARK_W]));
endmodule

bind lwf_write_formatter lwf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mark_pattern (mark_pattern),
    .in_valid     (in_valid),
    .row_odd      (row_odd),
    .csize        (csize),
    .lo_we        (lo_we),
    .lo_data      (lo_data),
    .hi_we        (hi_we),
    .hi_data      (hi_data),
    .side_we      (side_we)
);

// File: tb/sim_lwf_write_formatter.sv
module sim_lwf_write_formatter;
    import lwf_pkg::*;
    localparam int AW = 32;
    localparam logic [MARK_W-1:0] MARK = 15'h5A3C;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, row_odd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LINE_W-1:0] line = '0;
    logic [SIZE_W-1:0] csize = '0;
    logic [PAY_W-1:0] payload = '0;
    logic lo_we, hi_we, side_we, side_bit;
    logic [SUB_W-1:0] lo_data, hi_data;
    logic [AW-1:0] wr_addr;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lwf_write_formatter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .mark_pattern(MARK), .in_valid(in_valid),
        .addr(addr), .row_odd(row_odd), .line(line), .csize(csize),
        .payload(payload), .lo_we(lo_we), .lo_data(lo_data), .hi_we(hi_we),
        .hi_data(hi_data), .side_we(side_we), .side_bit(side_bit),
        .wr_addr(wr_addr)
    );

    typedef struct packed {
        logic [6:0] csz;
        logic       odd;
        logic       coll;
        logic       b15;
        logic [7:0] seed;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{7'd10, 1'b0, 1'b0, 1'b0, 8'h11},
        '{7'd10, 1'b1, 1'b0, 1'b0, 8'h22},
        '{7'd30, 1'b0, 1'b0, 1'b0, 8'h33},
        '{7'd30, 1'b1, 1'b0, 1'b0, 8'h44},
        '{7'd0,  1'b0, 1'b0, 1'b0, 8'h55},
        '{7'd31, 1'b0, 1'b0, 1'b0, 8'h66},
        '{7'd31, 1'b1, 1'b0, 1'b0, 8'h77},
        '{7'd64, 1'b1, 1'b0, 1'b0, 8'h88},
        '{7'd40, 1'b0, 1'b1, 1'b1, 8'h99},
        '{7'd40, 1'b1, 1'b1, 1'b1, 8'hAA},
        '{7'd50, 1'b0, 1'b1, 1'b0, 8'hBB},
        '{7'd20, 1'b1, 1'b1, 1'b1, 8'hCC}
    };

    task automatic check(input string tag, input logic [SUB_W-1:0] act,
                         input logic [SUB_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [LINE_W-1:0] ln;
        logic [PAY_W-1:0] pl, padded;
        logic [SUB_W-1:0] fh, sh, e_lo, e_hi;
        logic comp, e_side;
        for (int i = 0; i < LINE_BYTES; i++) ln[8*i +: 8] = 8'(v.seed + i * 37);
        if (v.coll) begin
            ln[MARK_W-1:0] = MARK;
            ln[MARK_W] = v.b15;
        end else if (ln[MARK_W-1:0] == MARK) begin
            ln[0] = ~ln[0];
        end
        for (int k = 0; k < PAY_BYTES; k++) pl[8*k +: 8] = 8'(v.seed * 3 + k + 1);
        for (int k = 0; k < PAY_BYTES; k++) padded[8*k +: 8] = (k < int'(v.csz)) ? pl[8*k +: 8] : 8'h00;
        comp = (v.csz <= 7'd30);
        fh = ln[SUB_W-1:0];
        sh = ln[LINE_W-1:SUB_W];
        e_side = !comp && v.coll;
        if (e_side) fh[MARK_W] = 1'b0;
        if (comp) begin
            e_lo = v.odd ? '0 : {padded, 1'b1, MARK};
            e_hi = v.odd ? {padded, 1'b1, MARK} : '0;
        end else begin
            e_lo = v.odd ? sh : fh;
            e_hi = v.odd ? fh : sh;
        end
        @(negedge clk);
        in_valid = 1'b1; row_odd = v.odd; line = ln; csize = v.csz;
        payload = pl; addr = 32'h1000 + idx * 64;
        @(negedge clk);
        in_valid = 1'b0;
        // R2 / R5: enables
        check(comp ? (v.odd ? "R5 odd-higher we" : "R5 even-lower we") : "R2 raw both we",
              SUB_W'({lo_we, hi_we}), SUB_W'({!(comp && v.odd), !(comp && !v.odd)}));
        // R3 / R4 / R6 / R7 data
        if (comp) begin
            check(v.csz < 7'd30 ? "R4 padded image" : "R3 header image", v.odd ? hi_data : lo_data, v.odd ? e_hi : e_lo);
            check("R3 idle sub-rank zero", v.odd ? lo_data : hi_data, '0);
        end else begin
            check(v.odd ? "R7 odd lo" : "R6 even lo", lo_data, e_lo);
            check(v.odd ? "R7 odd hi" : "R6 even hi", hi_data, e_hi);
        end
        // R8 side write
        check("R8 side write", SUB_W'({side_we, e_side ? side_bit : 1'b0}),
              SUB_W'({e_side, e_side ? v.b15 : 1'b0}));
        check("R9 address", SUB_W'(wr_addr), SUB_W'(32'h1000 + idx * 64));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1; csize = 7'd5;
        repeat (3) @(negedge clk);
        check("R1 reset enables", SUB_W'({lo_we, hi_we, side_we}), '0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 after reset", SUB_W'({lo_we, hi_we, side_we}), '0);
        for (int i = 0; i < 12; i++) run_vec(VECS[i], i);
        // R9: idle cycle after a request produces no enables
        @(negedge clk);
        check("R9 idle quiet", SUB_W'({lo_we, hi_we, side_we}), '0);
        // R8: raw line that collides but has valid low set only when raw
        run_vec('{7'd31, 1'b1, 1'b1, 1'b0, 8'h3D}, 12);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule